// File: doc/BRIEF.md
# Turbo Rapid-Fire Button Modulator

This block sits between a set of raw button levels and the parallel load inputs of a serial button reporter. Each button has its own turbo enable. A button whose turbo enable is low passes through unchanged. A button whose turbo enable is high is gated by a free-running square wave while it is held, so it alternates between pressed and released. The reporter's read protocol does not change. Only the values it loads are modulated.

The square wave comes from a local clock divider. It is not tied to any strobe or read activity from the host. Two reads taken close together therefore see the same value unless a half-period boundary falls between them. A two-bit rate input picks one of four half-period lengths. These range from the fast end of the rapid-fire band (30 Hz full period) to the slow end (15 Hz full period), and the lengths are derived from the system clock frequency parameter. Every turbo button shares the same phase.

All pins are plain level signals sampled every cycle. The block has no handshake, because button states have no notion of a transfer. Buttons are active high: 1 means pressed.

Top module: `turbo_modulator`

## Requirements
- R1: While reset is asserted, every bit of `btn_mod` is 0. The oscillator leaves reset in its "on" half. A turbo button that is held from the first clock after reset therefore reads 1 after that clock.
- R2: For a bit whose `turbo_en` is 0, `btn_mod` after a rising edge equals `btn_raw` sampled at that edge. This is exactly one register stage of delay.
- R3: For a bit whose `turbo_en` is 1 and whose `btn_raw` is 0, `btn_mod` after the edge is 0, whatever the oscillator phase.
- R4: For a bit whose `turbo_en` is 1 and whose `btn_raw` is 1, `btn_mod` after the edge equals the oscillator phase. The phase is 1 for H clocks, then 0 for H clocks, and so on, starting at the first edge after reset.
- R5: The half-period H in clocks is F + (S − F)·`rate_sel`/3. Here F = CLK_HZ/60 and S = CLK_HZ/30. `rate_sel` = 0 gives the fastest rate (30 Hz) and 3 gives the slowest (15 Hz).
- R6: In any cycle, all held turbo buttons report the same value, because they share one phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Rapid-fire rate choice, 0 fastest, 3 slowest |
| btn_raw | input | NUM_BTN | Raw button levels, 1 = pressed |
| turbo_en | input | NUM_BTN | Per-button turbo enable |
| btn_mod | output | NUM_BTN | Modulated button levels for the serial reporter |

## Verification
The period assertions assume that `rate_sel` changes only while reset is asserted. A change in mid-run would leave one half-period of a length between the old and new values. The stimulus sets the rate and then pulses reset before it sweeps each of the four rates. The pass-through, release and shared-phase assertions make no assumption about the buttons or enables. Both change every cycle in the stimulus, following arithmetic patterns that cover all combinations of held, released, turbo and plain bits.

// File: rtl/turbo_pkg.sv
package turbo_pkg;

  // Half-period in clocks for a given rate selection: linear steps from fast to slow.
  function automatic int unsigned half_clocks(input int unsigned fast_half,
                                              input int unsigned slow_half,
                                              input logic [1:0]  sel);
    return fast_half + ((slow_half - fast_half) * int'(sel)) / 3;
  endfunction

endpackage

// File: rtl/turbo_phase_gen.sv
module turbo_phase_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_len,
  output logic             phase
);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= half_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/turbo_gate_bank.sv
module turbo_gate_bank #(
  parameter int unsigned NUM_BTN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase,
  input  logic [NUM_BTN-1:0] btn_raw,
  input  logic [NUM_BTN-1:0] turbo_en,
  output logic [NUM_BTN-1:0] btn_mod
);

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
    logic gated;
    assign gated = btn_raw[i] & (~turbo_en[i] | phase);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) btn_mod[i] <= 1'b0;
      else        btn_mod[i] <= gated;
    end
  end

endmodule

// File: rtl/turbo_modulator.sv
module turbo_modulator #(
  parameter int unsigned NUM_BTN = 8,
  parameter int unsigned CLK_HZ  = 50_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         rate_sel,
  input  logic [NUM_BTN-1:0] btn_raw,
  input  logic [NUM_BTN-1:0] turbo_en,
  output logic [NUM_BTN-1:0] btn_mod
);

  // Full period 1/30 s at the fast end, 1/15 s at the slow end.
  localparam int unsigned HALF_FAST = CLK_HZ / 60;
  localparam int unsigned HALF_SLOW = CLK_HZ / 30;
  localparam int unsigned CNT_W     = $clog2(HALF_SLOW + 1);

  logic [CNT_W-1:0] half_len;
  logic             phase;

  always_comb begin
    half_len = CNT_W'(turbo_pkg::half_clocks(HALF_FAST, HALF_SLOW, rate_sel));
  end

  turbo_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_len (half_len),
    .phase    (phase)
  );

  turbo_gate_bank #(.NUM_BTN(NUM_BTN)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .btn_raw  (btn_raw),
    .turbo_en (turbo_en),
    .btn_mod  (btn_mod)
  );

endmodule

// File: rtl/turbo_modulator_chk.sv
module turbo_modulator_chk #(
  parameter int unsigned NUM_BTN = 8,
  parameter int unsigned CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_BTN-1:0] btn_raw,
  input logic [NUM_BTN-1:0] turbo_en,
  input logic [NUM_BTN-1:0] btn_mod,
  input logic [CNT_W-1:0]   half_len,
  input logic               phase
);

  logic             started;
  logic             prev_phase;
  logic [CNT_W:0]   run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started    <= 1'b0;
      prev_phase <= 1'b1;
      run        <= '0;
    end else begin
      started    <= 1'b1;
      prev_phase <= phase;
      run        <= (phase != prev_phase) ? (CNT_W+1)'(1) : run + (CNT_W+1)'(1);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!rst_n |-> btn_mod == '0));

  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((btn_mod ^ $past(btn_raw)) & ~$past(turbo_en)) == '0);

  // R3
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (btn_mod & ~$past(btn_raw)) == '0);

  // R6
  shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((btn_mod & $past(btn_raw & turbo_en)) == '0 ||
                 (btn_mod & $past(btn_raw & turbo_en)) == $past(btn_raw & turbo_en)));

  // R5
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != prev_phase) |-> run == {1'b0, half_len});

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= {1'b0, half_len});

endmodule

bind turbo_modulator turbo_modulator_chk #(.NUM_BTN(NUM_BTN), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .btn_raw  (btn_raw),
  .turbo_en (turbo_en),
  .btn_mod  (btn_mod),
  .half_len (half_len),
  .phase    (phase)
);

// File: tb/sim_turbo_modulator.sv
module sim_turbo_modulator;

  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    rate_sel = 2'd0;
  logic [NB-1:0] btn_raw = '0;
  logic [NB-1:0] turbo_en = '0;
  logic [NB-1:0] btn_mod;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  // CLK_HZ = 360 gives half-periods 6, 8, 10, 12 clocks for rate_sel 0..3.
  turbo_modulator #(.NUM_BTN(NB), .CLK_HZ(360)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .btn_raw(btn_raw), .turbo_en(turbo_en), .btn_mod(btn_mod)
  );

  task automatic check(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: held buttons during reset read released
    btn_raw  = '1;
    turbo_en = 8'h0F;
    repeat (3) @(negedge clk);
    check("R1 reset", btn_mod, '0);

    for (int sel = 0; sel < 4; sel++) begin
      int half;
      logic [NB-1:0] b, e;
      half = 6 + 2 * sel;
      @(negedge clk);
      rst_n    = 1'b0;
      rate_sel = 2'(sel);
      @(negedge clk);
      check("R1 reset", btn_mod, '0);
      rst_n    = 1'b1;
      b        = '1;
      e        = '1;
      btn_raw  = b;
      turbo_en = e;
      for (int k = 1; k <= 4 * half + 3; k++) begin
        logic          ph;
        logic [NB-1:0] held, act;
        @(negedge clk);
        act  = btn_mod;
        ph   = 1'b1 ^ 1'(((k - 1) / half) & 1);
        held = b & e;
        if (k == 1) check("R1 phase starts on", act, '1);
        check("R2 pass-through", act & ~e, b & ~e);
        check("R3 released turbo", act & ~b & e, '0);
        check("R4/R5 turbo phase", act & held, ph ? held : '0);
        if (held != '0) begin
          checks++;
          if ((act & held) != '0 && (act & held) != held) begin
            errors++;
            $display("FAIL R6 shared phase: actual %b expected all-or-none of %b", act & held, held);
          end
        end
        b = NB'(k * 37 + sel * 11);
        if (k % 5 == 0) b = '1;
        e = NB'((k * 13) ^ 8'h5A);
        if (k % 7 == 0) e = '1;
        btn_raw  = b;
        turbo_en = e;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule